// File: doc/BRIEF.md
# I2C Controller Status Flag Unit

This block keeps the event and error flags of an I2C controller. The bus engine sends it one-cycle pulses: address match, NACK after a transmitted byte, STOP seen on the bus, byte transferred, misplaced START/STOP, arbitration loss, overrun/underrun and a bad received PEC byte. The block qualifies each pulse against the current mode (enable, master or slave, reload, auto-end, no-stretch, slave byte control) and latches it into a read-only status word.

Software clears flags in several ways. Most flags have their own write-one-to-clear bit. The two transfer-complete flags are cleared by the actions that continue a transfer: a non-zero count write or a START/STOP request. Dropping the enable wipes every flag. An internal down-counter loads the programmed byte count and tracks how many bytes remain. When it runs out, the block raises a transfer-complete flag or, in auto-end mode, asks the bus engine for a STOP.

Top module: `i2c_flag_unit`

## Requirements
- R1: While `enable` is 0, every bit of `statusWord` reads 0 from the next cycle on. Events that arrive while disabled are dropped.
- R2: A `evPecBad` pulse sets the PEC flag and makes `pecNack` high for exactly one cycle, in the same cycle the flag first reads 1. Clear bit 6 clears the flag. With `SMBUS_EN=0` the flag stays 0.
- R3: `evOvrUdr` sets the overrun flag only when `isMaster=0` and `noStretch=1`. Clear bit 5 clears it.
- R4: `evMisplaced` sets the bus-error flag only while the controller is in a transfer, and never in slave mode while `addrPhase=1`. Clear bit 3 clears it. A transfer starts on a master `startReq` or a slave `evAddrMatch`, and ends on `evStop`.
- R5: The reload flag sets when `reloadMode=1` and the byte counter runs out. A `countWrite` with a non-zero `byteCount` clears it. Nothing else clears it except R1.
- R6: Neither transfer-complete flag sets in slave mode unless `slaveByteCtl=1`. Both can set in master mode.
- R7: The transfer-complete flag sets when the counter runs out with `reloadMode=0` and `autoEnd=0`. It is cleared by `startReq` or `stopReq`, and not by the clear bits.
- R8: `evStop` sets the STOP flag only during a transfer. As master, `evStopOwn` must also be 1. As slave, an address match must have come earlier in that transfer. Clear bit 2 clears it.
- R9: `statusWord` layout: bit0 address, bit1 NACK, bit2 STOP, bit3 transfer-complete, bit4 reload, bit5 bus error, bit6 arbitration lost, bit7 overrun, bit8 PEC. `clrBits` layout: bit0 address, bit1 NACK, bit2 STOP, bit3 bus error, bit4 arbitration lost, bit5 overrun, bit6 PEC. `evAddrMatch`, `evNack` and `evArbLost` set their flags unconditionally while enabled.
- R10: With `reloadMode=0` and `autoEnd=1`, running out of bytes pulses `autoStop` for one cycle and sets neither transfer-complete flag.
- R11: A set event and its clear bit in the same cycle leave the flag at 1.
- R12: `bytesLeft` loads `byteCount` on `startReq` or on a non-zero `countWrite`. It decrements by one on each `evByteDone` while non-zero. The counter runs out on the pulse that takes it from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; 0 wipes all flags |
| isMaster | input | 1 | 1 = master mode, 0 = slave mode |
| reloadMode | input | 1 | Byte count is reloaded per chunk |
| autoEnd | input | 1 | Issue STOP automatically at count end |
| noStretch | input | 1 | Clock stretching disabled |
| slaveByteCtl | input | 1 | Slave byte counting enabled |
| byteCount | input | CNT_W | Programmed byte count |
| countWrite | input | 1 | Software write of `byteCount` |
| startReq | input | 1 | Software START request |
| stopReq | input | 1 | Software STOP request |
| evAddrMatch | input | 1 | Own address matched |
| evNack | input | 1 | NACK received after a sent byte |
| evStop | input | 1 | STOP detected on the bus |
| evStopOwn | input | 1 | That STOP was generated by this controller |
| evByteDone | input | 1 | One byte transferred |
| evMisplaced | input | 1 | START/STOP in an illegal position |
| addrPhase | input | 1 | Bus engine is in the address phase |
| evArbLost | input | 1 | Arbitration lost |
| evOvrUdr | input | 1 | Overrun or underrun |
| evPecBad | input | 1 | Received PEC mismatched |
| clrBits | input | 7 | Write-one-to-clear pulses (R9 layout) |
| statusWord | output | 9 | Flag word (R9 layout) |
| bytesLeft | output | CNT_W | Remaining bytes in the counter |
| autoStop | output | 1 | STOP request to the bus engine |
| pecNack | output | 1 | Request to NACK after a bad PEC |

## Verification
Each flag is driven with its event under both the mode that must let it through and the mode that must block it. This separates a correct qualifier from a missing or inverted one: no-stretch against stretch, address phase against data phase, own STOP against foreign STOP, and addressed slave against idle slave. The byte counter is run to exhaustion under three settings. Reload-off with auto-end off, reload-on, and auto-end on must each lead to a different single outcome. Slave mode is run with byte control off and on. The clear paths are tried against the wrong clear source as well as the right one: clear bits on the transfer-complete flag, a zero count write on the reload flag. A simultaneous set and clear shows which one has priority.

// File: rtl/i2cflag_pkg.sv
package i2cflag_pkg;
  localparam int F_ADDR  = 0;
  localparam int F_NACK  = 1;
  localparam int F_STOP  = 2;
  localparam int F_TC    = 3;
  localparam int F_TCR   = 4;
  localparam int F_BERR  = 5;
  localparam int F_ARLO  = 6;
  localparam int F_OVR   = 7;
  localparam int F_PEC   = 8;
  localparam int N_FLAGS = 9;

  localparam int C_ADDR  = 0;
  localparam int C_NACK  = 1;
  localparam int C_STOP  = 2;
  localparam int C_BERR  = 3;
  localparam int C_ARLO  = 4;
  localparam int C_OVR   = 5;
  localparam int C_PEC   = 6;
  localparam int N_CLR   = 7;

  typedef struct packed {
    logic [N_FLAGS-1:0] setVec;
    logic [N_FLAGS-1:0] clrVec;
    logic               loadCnt;
    logic               decCnt;
    logic               autoStop;
    logic               pecNack;
    logic               xferBegin;
    logic               xferEnd;
    logic               wipe;
  } strobes_t;
endpackage

// File: rtl/i2cflag_ctrl.sv
module i2cflag_ctrl
  import i2cflag_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter bit SMBUS_EN = 1'b1
) (
  input  logic             enable,
  input  logic             isMaster,
  input  logic             reloadMode,
  input  logic             autoEnd,
  input  logic             noStretch,
  input  logic             slaveByteCtl,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             countWrite,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic             evAddrMatch,
  input  logic             evNack,
  input  logic             evStop,
  input  logic             evStopOwn,
  input  logic             evByteDone,
  input  logic             evMisplaced,
  input  logic             addrPhase,
  input  logic             evArbLost,
  input  logic             evOvrUdr,
  input  logic             evPecBad,
  input  logic [N_CLR-1:0] clrBits,
  input  logic [CNT_W-1:0] bytesLeft,
  input  logic             inXfer,
  output strobes_t         st
);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(1);

  logic exhaust;
  logic tcAllowed;
  logic nonZeroWr;
  logic slaveAddrPhase;
  logic stopInvolved;
  logic pecHit;

  generate
    if (SMBUS_EN) begin : g_pec
      assign pecHit = evPecBad;
    end else begin : g_nopec
      assign pecHit = 1'b0;
    end
  endgenerate

  always_comb begin
    exhaust        = evByteDone && (bytesLeft == LAST_BYTE);
    tcAllowed      = isMaster || slaveByteCtl;
    nonZeroWr      = countWrite && (byteCount != '0);
    slaveAddrPhase = !isMaster && addrPhase;
    stopInvolved   = evStop && inXfer && (isMaster ? evStopOwn : 1'b1);

    st = '0;
    st.wipe = !enable;
    if (enable) begin
      st.setVec[F_ADDR] = evAddrMatch;
      st.setVec[F_NACK] = evNack;
      st.setVec[F_STOP] = stopInvolved;
      st.setVec[F_TC]   = exhaust && tcAllowed && !reloadMode && !autoEnd;
      st.setVec[F_TCR]  = exhaust && tcAllowed && reloadMode;
      st.setVec[F_BERR] = evMisplaced && inXfer && !slaveAddrPhase;
      st.setVec[F_ARLO] = evArbLost;
      st.setVec[F_OVR]  = evOvrUdr && !isMaster && noStretch;
      st.setVec[F_PEC]  = pecHit;

      st.clrVec[F_ADDR] = clrBits[C_ADDR];
      st.clrVec[F_NACK] = clrBits[C_NACK];
      st.clrVec[F_STOP] = clrBits[C_STOP];
      st.clrVec[F_TC]   = startReq || stopReq;
      st.clrVec[F_TCR]  = nonZeroWr;
      st.clrVec[F_BERR] = clrBits[C_BERR];
      st.clrVec[F_ARLO] = clrBits[C_ARLO];
      st.clrVec[F_OVR]  = clrBits[C_OVR];
      st.clrVec[F_PEC]  = clrBits[C_PEC];

      st.loadCnt   = startReq || nonZeroWr;
      st.decCnt    = evByteDone && (bytesLeft != '0);
      st.autoStop  = exhaust && tcAllowed && !reloadMode && autoEnd;
      st.pecNack   = pecHit;
      st.xferBegin = (startReq && isMaster) || (evAddrMatch && !isMaster);
      st.xferEnd   = evStop;
    end
  end
endmodule

// File: rtl/i2cflag_dp.sv
module i2cflag_dp
  import i2cflag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           st,
  input  logic [CNT_W-1:0]   byteCount,
  output logic [N_FLAGS-1:0] flags,
  output logic [CNT_W-1:0]   bytesLeft,
  output logic               inXfer,
  output logic               autoStop,
  output logic               pecNack
);
  generate
    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               flags[i] <= 1'b0;
        else if (st.wipe)        flags[i] <= 1'b0;
        else if (st.setVec[i])   flags[i] <= 1'b1;
        else if (st.clrVec[i])   flags[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            bytesLeft <= '0;
    else if (st.wipe)     bytesLeft <= '0;
    else if (st.loadCnt)  bytesLeft <= byteCount;
    else if (st.decCnt)   bytesLeft <= bytesLeft - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              inXfer <= 1'b0;
    else if (st.wipe)       inXfer <= 1'b0;
    else if (st.xferEnd)    inXfer <= 1'b0;
    else if (st.xferBegin)  inXfer <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoStop <= 1'b0;
      pecNack  <= 1'b0;
    end else begin
      autoStop <= st.autoStop;
      pecNack  <= st.pecNack;
    end
  end
endmodule

// File: rtl/i2c_flag_unit.sv
module i2c_flag_unit
  import i2cflag_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter bit SMBUS_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               isMaster,
  input  logic               reloadMode,
  input  logic               autoEnd,
  input  logic               noStretch,
  input  logic               slaveByteCtl,
  input  logic [CNT_W-1:0]   byteCount,
  input  logic               countWrite,
  input  logic               startReq,
  input  logic               stopReq,
  input  logic               evAddrMatch,
  input  logic               evNack,
  input  logic               evStop,
  input  logic               evStopOwn,
  input  logic               evByteDone,
  input  logic               evMisplaced,
  input  logic               addrPhase,
  input  logic               evArbLost,
  input  logic               evOvrUdr,
  input  logic               evPecBad,
  input  logic [N_CLR-1:0]   clrBits,
  output logic [N_FLAGS-1:0] statusWord,
  output logic [CNT_W-1:0]   bytesLeft,
  output logic               autoStop,
  output logic               pecNack
);
  strobes_t stb;
  logic     inXfer;

  i2cflag_ctrl #(.CNT_W(CNT_W), .SMBUS_EN(SMBUS_EN)) u_ctrl (
    .enable(enable), .isMaster(isMaster), .reloadMode(reloadMode),
    .autoEnd(autoEnd), .noStretch(noStretch), .slaveByteCtl(slaveByteCtl),
    .byteCount(byteCount), .countWrite(countWrite), .startReq(startReq),
    .stopReq(stopReq), .evAddrMatch(evAddrMatch), .evNack(evNack),
    .evStop(evStop), .evStopOwn(evStopOwn), .evByteDone(evByteDone),
    .evMisplaced(evMisplaced), .addrPhase(addrPhase), .evArbLost(evArbLost),
    .evOvrUdr(evOvrUdr), .evPecBad(evPecBad), .clrBits(clrBits),
    .bytesLeft(bytesLeft), .inXfer(inXfer), .st(stb)
  );

  i2cflag_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(stb), .byteCount(byteCount),
    .flags(statusWord), .bytesLeft(bytesLeft), .inXfer(inXfer),
    .autoStop(autoStop), .pecNack(pecNack)
  );
endmodule

// File: rtl/i2cflag_chk.sv
module i2cflag_chk
  import i2cflag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               isMaster,
  input logic               noStretch,
  input logic               addrPhase,
  input logic               countWrite,
  input logic [CNT_W-1:0]   byteCount,
  input logic               startReq,
  input logic               stopReq,
  input logic               evNack,
  input logic [N_CLR-1:0]   clrBits,
  input logic [N_FLAGS-1:0] statusWord,
  input logic               autoStop,
  input logic               pecNack
);
  p_off_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (statusWord == '0));

  p_pec_nack_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[F_PEC]) |-> pecNack);

  p_ovr_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[F_OVR]) |-> $past(!isMaster && noStretch));

  p_berr_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[F_BERR]) |-> $past(isMaster || !addrPhase));

  p_tcr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[F_TCR] && enable && !(countWrite && byteCount != '0))
      |=> statusWord[F_TCR]);

  p_tc_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusWord[F_TC]) |-> $past(startReq || stopReq || !enable));

  p_auto_no_tc_r10: assert property (@(posedge clk) disable iff (!rstN)
    autoStop |-> !$rose(statusWord[F_TC]) && !$rose(statusWord[F_TCR]));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enable && evNack && clrBits[C_NACK]) |=> statusWord[F_NACK]);
endmodule

bind i2c_flag_unit i2cflag_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster),
  .noStretch(noStretch), .addrPhase(addrPhase), .countWrite(countWrite),
  .byteCount(byteCount), .startReq(startReq), .stopReq(stopReq),
  .evNack(evNack), .clrBits(clrBits), .statusWord(statusWord),
  .autoStop(autoStop), .pecNack(pecNack)
);

// File: tb/sim_i2c_flag_unit.sv
module sim_i2c_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int B_ADDR = 0, B_NACK = 1, B_STOP = 2, B_TC = 3, B_TCR = 4;
  localparam int B_BERR = 5, B_ARLO = 6, B_OVR = 7, B_PEC = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 0, isMaster = 0, reloadMode = 0, autoEnd = 0, noStretch = 0;
  logic slaveByteCtl = 0, countWrite = 0, startReq = 0, stopReq = 0;
  logic evAddrMatch = 0, evNack = 0, evStop = 0, evStopOwn = 0, evByteDone = 0;
  logic evMisplaced = 0, addrPhase = 0, evArbLost = 0, evOvrUdr = 0, evPecBad = 0;
  logic [CW-1:0] byteCount = '0;
  logic [6:0] clrBits = '0;
  logic [8:0] statusWord;
  logic [CW-1:0] bytesLeft;
  logic autoStop, pecNack;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_flag_unit #(.CNT_W(CW), .SMBUS_EN(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster),
    .reloadMode(reloadMode), .autoEnd(autoEnd), .noStretch(noStretch),
    .slaveByteCtl(slaveByteCtl), .byteCount(byteCount), .countWrite(countWrite),
    .startReq(startReq), .stopReq(stopReq), .evAddrMatch(evAddrMatch),
    .evNack(evNack), .evStop(evStop), .evStopOwn(evStopOwn),
    .evByteDone(evByteDone), .evMisplaced(evMisplaced), .addrPhase(addrPhase),
    .evArbLost(evArbLost), .evOvrUdr(evOvrUdr), .evPecBad(evPecBad),
    .clrBits(clrBits), .statusWord(statusWord), .bytesLeft(bytesLeft),
    .autoStop(autoStop), .pecNack(pecNack)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [8:0] bitOf(input int b);
    return 9'(1) << b;
  endfunction

  task automatic clearAll();
    clrBits = 7'h7F; cyc(); clrBits = '0;
  endtask

  task automatic t_reset();
    chk("R1", "reset status", statusWord, 9'h0);
    chk("R12", "reset count", bytesLeft, 0);
    chk("R10", "reset autoStop", autoStop, 0);
  endtask

  task automatic t_simple_flags();
    isMaster = 0;
    evAddrMatch = 1; cyc(); evAddrMatch = 0;
    chk("R9", "address flag", statusWord, bitOf(B_ADDR));
    evNack = 1; cyc(); evNack = 0;
    evArbLost = 1; cyc(); evArbLost = 0;
    chk("R9", "addr+nack+arlo", statusWord, bitOf(B_ADDR) | bitOf(B_NACK) | bitOf(B_ARLO));
    clrBits = 7'b0000011; cyc(); clrBits = '0;
    chk("R9", "clear addr/nack keeps arlo", statusWord, bitOf(B_ARLO));
    clrBits = 7'b0010000; cyc(); clrBits = '0;
    chk("R9", "clear arlo via bit4", statusWord, 9'h0);
  endtask

  task automatic t_set_wins();
    evNack = 1; clrBits = 7'b0000010; cyc(); evNack = 0; clrBits = '0;
    chk("R11", "set beats clear", statusWord[B_NACK], 1);
    clearAll();
    chk("R11", "later clear works", statusWord, 9'h0);
  endtask

  task automatic t_stop();
    isMaster = 1;
    evStop = 1; evStopOwn = 0; cyc(); evStop = 0;
    evStop = 1; evStopOwn = 1; cyc(); evStop = 0; evStopOwn = 0;
    chk("R8", "master idle stop ignored", statusWord[B_STOP], 0);
    startReq = 1; cyc(); startReq = 0;
    evStop = 1; evStopOwn = 0; cyc(); evStop = 0;
    chk("R8", "foreign stop ignored", statusWord[B_STOP], 0);
    startReq = 1; cyc(); startReq = 0;
    evStop = 1; evStopOwn = 1; cyc(); evStop = 0; evStopOwn = 0;
    chk("R8", "own stop sets", statusWord[B_STOP], 1);
    clrBits = 7'b0000100; cyc(); clrBits = '0;
    chk("R8", "stop clear bit2", statusWord[B_STOP], 0);
    isMaster = 0;
    evStop = 1; cyc(); evStop = 0;
    chk("R8", "unaddressed slave stop ignored", statusWord[B_STOP], 0);
    evAddrMatch = 1; cyc(); evAddrMatch = 0;
    evStop = 1; cyc(); evStop = 0;
    chk("R8", "addressed slave stop sets", statusWord[B_STOP], 1);
    clearAll();
  endtask

  task automatic t_berr();
    isMaster = 0;
    evAddrMatch = 1; cyc(); evAddrMatch = 0;
    addrPhase = 1; evMisplaced = 1; cyc(); evMisplaced = 0; addrPhase = 0;
    chk("R4", "no berr in address phase", statusWord[B_BERR], 0);
    evMisplaced = 1; cyc(); evMisplaced = 0;
    chk("R4", "berr in data phase", statusWord[B_BERR], 1);
    clrBits = 7'b0001000; cyc(); clrBits = '0;
    chk("R4", "berr clear bit3", statusWord[B_BERR], 0);
    evStop = 1; cyc(); evStop = 0;
    evMisplaced = 1; cyc(); evMisplaced = 0;
    chk("R4", "no berr outside transfer", statusWord[B_BERR], 0);
    clearAll();
  endtask

  task automatic t_ovr();
    isMaster = 1; noStretch = 1;
    evOvrUdr = 1; cyc(); evOvrUdr = 0;
    chk("R3", "master ignores ovr", statusWord[B_OVR], 0);
    isMaster = 0; noStretch = 0;
    evOvrUdr = 1; cyc(); evOvrUdr = 0;
    chk("R3", "stretching slave ignores ovr", statusWord[B_OVR], 0);
    noStretch = 1;
    evOvrUdr = 1; cyc(); evOvrUdr = 0;
    chk("R3", "no-stretch slave sets ovr", statusWord[B_OVR], 1);
    clrBits = 7'b0100000; cyc(); clrBits = '0;
    chk("R3", "ovr clear bit5", statusWord[B_OVR], 0);
    noStretch = 0;
  endtask

  task automatic t_pec();
    evPecBad = 1; cyc(); evPecBad = 0;
    chk("R2", "pec flag", statusWord[B_PEC], 1);
    chk("R2", "auto nack", pecNack, 1);
    cyc();
    chk("R2", "nack one cycle", pecNack, 0);
    clrBits = 7'b1000000; cyc(); clrBits = '0;
    chk("R2", "pec clear bit6", statusWord[B_PEC], 0);
  endtask

  task automatic t_tc();
    isMaster = 1; reloadMode = 0; autoEnd = 0; byteCount = 8'd2;
    startReq = 1; cyc(); startReq = 0;
    chk("R12", "load on start", bytesLeft, 2);
    evByteDone = 1; cyc(); evByteDone = 0;
    chk("R12", "decrement", bytesLeft, 1);
    chk("R7", "tc not yet", statusWord[B_TC], 0);
    evByteDone = 1; cyc(); evByteDone = 0;
    chk("R7", "tc at end", statusWord[B_TC], 1);
    chk("R12", "count empty", bytesLeft, 0);
    evByteDone = 1; cyc(); evByteDone = 0;
    chk("R12", "no wrap below zero", bytesLeft, 0);
    clearAll();
    chk("R7", "clear bits leave tc", statusWord[B_TC], 1);
    stopReq = 1; cyc(); stopReq = 0;
    chk("R7", "stop request clears tc", statusWord[B_TC], 0);
  endtask

  task automatic t_tcr();
    isMaster = 1; reloadMode = 1; byteCount = 8'd2;
    startReq = 1; cyc(); startReq = 0;
    evByteDone = 1; cyc(); cyc(); evByteDone = 0;
    chk("R5", "tcr at end", statusWord, bitOf(B_TCR));
    byteCount = 8'd0; countWrite = 1; cyc(); countWrite = 0;
    chk("R5", "zero write keeps tcr", statusWord[B_TCR], 1);
    clearAll();
    chk("R5", "clear bits keep tcr", statusWord[B_TCR], 1);
    byteCount = 8'd3; countWrite = 1; cyc(); countWrite = 0;
    chk("R5", "nonzero write clears tcr", statusWord[B_TCR], 0);
    chk("R12", "reload on count write", bytesLeft, 3);
    reloadMode = 0;
  endtask

  task automatic t_autoend();
    isMaster = 1; reloadMode = 0; autoEnd = 1; byteCount = 8'd1;
    startReq = 1; cyc(); startReq = 0;
    evByteDone = 1; cyc(); evByteDone = 0;
    chk("R10", "auto stop pulse", autoStop, 1);
    chk("R10", "no tc flags", statusWord & (bitOf(B_TC) | bitOf(B_TCR)), 0);
    cyc();
    chk("R10", "auto stop one cycle", autoStop, 0);
    autoEnd = 0;
  endtask

  task automatic t_slave_gate();
    isMaster = 0; slaveByteCtl = 0; byteCount = 8'd1;
    countWrite = 1; cyc(); countWrite = 0;
    evByteDone = 1; cyc(); evByteDone = 0;
    chk("R6", "slave without byte ctl no tc", statusWord[B_TC], 0);
    slaveByteCtl = 1;
    countWrite = 1; cyc(); countWrite = 0;
    evByteDone = 1; cyc(); evByteDone = 0;
    chk("R6", "slave with byte ctl tc", statusWord[B_TC], 1);
  endtask

  task automatic t_disable();
    evNack = 1; cyc(); evNack = 0;
    enable = 0; cyc();
    chk("R1", "disable wipes", statusWord, 9'h0);
    evNack = 1; evArbLost = 1; cyc(); evNack = 0; evArbLost = 0;
    chk("R1", "events dropped while off", statusWord, 9'h0);
    enable = 1; cyc();
    chk("R1", "re-enable stays clear", statusWord, 9'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rstN = 1; cyc();
    enable = 1; cyc();
    t_simple_flags();
    t_set_wins();
    t_stop();
    t_berr();
    t_ovr();
    t_pec();
    t_tc();
    t_tcr();
    t_autoend();
    t_slave_gate();
    t_disable();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule